// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block is the interrupt front end of a small 8-bit microcontroller. It watches two dedicated external interrupt pins and sixteen general-purpose pin-change inputs. Each pin goes through a synchroniser, and the block then detects levels, edges or changes on it. The results are stored as flags in a byte-wide register file. The block drives one request line per interrupt vector to the CPU's interrupt logic.

Software uses a small register bus to set the enables, pick the sense mode of the external pins, choose which pin-change inputs take part, and clear flags. The CPU clears a flag in hardware by pulsing the acknowledge input of the matching vector when it takes that vector. Detection works on the pad value, so a pin still raises events when it is driven as an output.

Top module: `irq_front_end`

## Requirements
- R1: The enable register at address 0x3B holds external-1 enable at bit 7, external-0 enable at bit 6, pin-change group-1 enable at bit 5 and pin-change group-0 enable at bit 4. Bits 3..0 read as zero. After reset it reads 0x00.
- R2: The flag register at address 0x3A holds external-1 flag at bit 7, external-0 flag at bit 6 and the shared pin-change flag at bit 5. Bits 4..0 read as zero. After reset it reads 0x00.
- R3: A request output is high only when its enable bit is set and `gie` is high, together with its flag (or, in low-level mode, the pin level of R5). It is low otherwise.
- R4: The sense register at address 0x35 holds a shared 2-bit mode in bits 1..0 that applies to both external pins: 00 low level, 01 any change, 10 falling edge, 11 rising edge. Bits 7..2 read as zero. In an edge mode, a matching transition sets the flag at the third rising clock edge after the pin changes. A non-matching transition leaves the flag clear.
- R5: In low-level mode no external flag is set. The request is asserted from the second clock edge after the pin goes low, while the enable is set and `gie` is high. It drops at the second edge after the pin goes high.
- R6: Group-1 enable covers pin-change inputs 0–7 and 12–15, and group-0 enable covers inputs 8–11. A change on an input sets the shared pin-change flag only if the group enable covering that input is set. The pin-change request also needs at least one group enable set.
- R7: The pin-change mask registers are at 0x23 (inputs 7..0, bit n = input n) and 0x22 (inputs 15..8, bit n = input n+8). A change on an input whose mask bit is 0 leaves the pin-change flag unchanged.
- R8: Writing 1 to an implemented flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: A one-cycle pulse on `ack_ext0`, `ack_ext1` or `ack_pc` clears the matching flag at that clock edge.
- R10: When a set event and a clear (write or acknowledge) reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable from the CPU |
| ext_pin | input | 2 | External interrupt pads (bit 0 = external 0) |
| pc_pin | input | 16 | Pin-change pads |
| ack_ext0 | input | 1 | Vector-taken pulse, external 0 |
| ack_ext1 | input | 1 | Vector-taken pulse, external 1 |
| ack_pc | input | 1 | Vector-taken pulse, pin change |
| irq_ext0 | output | 1 | Request, external 0 |
| irq_ext1 | output | 1 | Request, external 1 |
| irq_pc | output | 1 | Request, pin change |

## Verification
The assertions assume that the pads are only sampled after the reset synchronisers have been filled with the same low level the bench holds during reset. They also assume that sense, enable and mask values change only through a bus write. The "no new flag" checks are therefore conditioned on the absence of a write in that cycle. The stimulus holds every pad low through reset and changes pads and strobes only at falling clock edges. Between test points it lets the pins settle for several cycles and clears the flags by writing ones, so each observed flag comes from exactly one intended transition.

// File: rtl/irq_pkg.sv
// Package: shared addresses, field positions and sense-mode encoding for the
// interrupt front end. Assumes a 6-bit I/O address space.
package irq_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;
    localparam int EXT_N    = 2;
    localparam int PC_N     = 16;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 6'h3B;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 6'h3A;
    localparam logic [ADDR_W-1:0] ADR_MSK_LO = 6'h23;
    localparam logic [ADDR_W-1:0] ADR_MSK_HI = 6'h22;
    localparam logic [ADDR_W-1:0] ADR_SENSE  = 6'h35;

    // Bit positions shared by the enable and flag registers
    localparam int BIT_EXT1 = 7;
    localparam int BIT_EXT0 = 6;
    localparam int BIT_PC   = 5;   // flag register
    localparam int BIT_G1   = 5;   // enable register, group 1
    localparam int BIT_G0   = 4;   // enable register, group 0

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;
endpackage

// File: rtl/irq_sync.sv
// Module: two-flop synchroniser plus a history flop per bit.
// Outputs the synchronised sample and the sample from one cycle earlier, so
// the consumers can detect edges. Assumes the inputs are asynchronous pads.
module irq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    // Capture the pad, settle it, then keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= pad;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/irq_ext_sense.sv
// Module: per-pin event decoder for the external interrupt pins.
// Turns a synchronised sample pair into an edge event according to the shared
// sense mode, and reports the low level separately. Purely combinational.
module irq_ext_sense
    import irq_pkg::*;
#(
    parameter int N = 2
) (
    input  sense_e       mode,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    output logic [N-1:0] hit,
    output logic [N-1:0] low
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        // Decode one pin's event for the selected mode
        always_comb begin
            low[i] = ~cur[i];
            unique case (mode)
                SNS_ANY:  hit[i] = cur[i] ^ prev[i];
                SNS_FALL: hit[i] = prev[i] & ~cur[i];
                SNS_RISE: hit[i] = cur[i] & ~prev[i];
                default:  hit[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_pc_detect.sv
// Module: pin-change detector with per-pin masks and two uneven groups.
// Pins G0_LO..G0_HI belong to group 0, all others to group 1. A pin
// contributes when it changed, its mask bit is set and its group is enabled.
module irq_pc_detect #(
    parameter int N     = 16,
    parameter int G0_LO = 8,
    parameter int G0_HI = 11
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mask,
    input  logic         grp0_en,
    input  logic         grp1_en,
    output logic         any_hit
);
    logic [N-1:0] pin_hit;

    for (genvar i = 0; i < N; i++) begin : g_pin
        localparam bit IN_G0 = (i >= G0_LO) && (i <= G0_HI);
        if (IN_G0) begin : g_grp0
            // Qualify a change on a group-0 pin
            assign pin_hit[i] = (cur[i] ^ prev[i]) & mask[i] & grp0_en;
        end else begin : g_grp1
            // Qualify a change on a group-1 pin
            assign pin_hit[i] = (cur[i] ^ prev[i]) & mask[i] & grp1_en;
        end
    end

    // Merge all qualified pins into the single shared event
    assign any_hit = |pin_hit;
endmodule

// File: rtl/irq_front_end.sv
// Module: external and pin-change interrupt front end (top).
// Holds the enable, flag, sense and mask registers on a byte-wide bus, runs
// pad detection, and drives per-vector requests gated by gie. Assumes one
// bus write per strobe cycle and single-cycle acknowledge pulses.
module irq_front_end
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie,
    input  logic [EXT_N-1:0]  ext_pin,
    input  logic [PC_N-1:0]   pc_pin,
    input  logic              ack_ext0,
    input  logic              ack_ext1,
    input  logic              ack_pc,
    output logic              irq_ext0,
    output logic              irq_ext1,
    output logic              irq_pc
);
    localparam int MSK_W = PC_N / 2;

    logic [3:0]       en_q;          // {ext1, ext0, g1, g0}
    sense_e           sense_q;
    logic [PC_N-1:0]  mask_q;
    logic             fl_e0, fl_e1, fl_pc;

    logic [EXT_N-1:0] ext_cur, ext_prev, ext_hit, ext_low;
    logic [PC_N-1:0]  pc_cur, pc_prev;
    logic             pc_hit;

    logic wr_en, wr_flag, wr_sense, wr_lo, wr_hi;
    logic clr_e0, clr_e1, clr_pc;

    irq_sync #(.W(EXT_N)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .pad(ext_pin), .cur(ext_cur), .prev(ext_prev)
    );

    irq_sync #(.W(PC_N)) u_pc_sync (
        .clk(clk), .rst_n(rst_n), .pad(pc_pin), .cur(pc_cur), .prev(pc_prev)
    );

    irq_ext_sense #(.N(EXT_N)) u_ext_sense (
        .mode(sense_q), .cur(ext_cur), .prev(ext_prev), .hit(ext_hit), .low(ext_low)
    );

    irq_pc_detect #(.N(PC_N), .G0_LO(8), .G0_HI(11)) u_pc_detect (
        .cur(pc_cur), .prev(pc_prev), .mask(mask_q),
        .grp0_en(en_q[0]), .grp1_en(en_q[1]), .any_hit(pc_hit)
    );

    // Decode which register a write strobe targets
    always_comb begin
        wr_en    = bus_wr && (bus_addr == ADR_ENABLE);
        wr_flag  = bus_wr && (bus_addr == ADR_FLAG);
        wr_sense = bus_wr && (bus_addr == ADR_SENSE);
        wr_lo    = bus_wr && (bus_addr == ADR_MSK_LO);
        wr_hi    = bus_wr && (bus_addr == ADR_MSK_HI);
    end

    // Combine write-one-to-clear and vector acknowledge into clear strobes
    always_comb begin
        clr_e0 = (wr_flag && bus_wdata[BIT_EXT0]) || ack_ext0;
        clr_e1 = (wr_flag && bus_wdata[BIT_EXT1]) || ack_ext1;
        clr_pc = (wr_flag && bus_wdata[BIT_PC])   || ack_pc;
    end

    // Hold the software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            sense_q <= SNS_LOW;
            mask_q  <= '0;
        end else begin
            if (wr_en)    en_q    <= bus_wdata[7:4];
            if (wr_sense) sense_q <= sense_e'(bus_wdata[1:0]);
            if (wr_lo)    mask_q[MSK_W-1:0]    <= bus_wdata;
            if (wr_hi)    mask_q[PC_N-1:MSK_W] <= bus_wdata;
        end
    end

    // Update the flags, a set event taking priority over any clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_e0 <= 1'b0;
            fl_e1 <= 1'b0;
            fl_pc <= 1'b0;
        end else begin
            if (ext_hit[0])  fl_e0 <= 1'b1;
            else if (clr_e0) fl_e0 <= 1'b0;
            if (ext_hit[1])  fl_e1 <= 1'b1;
            else if (clr_e1) fl_e1 <= 1'b0;
            if (pc_hit)      fl_pc <= 1'b1;
            else if (clr_pc) fl_pc <= 1'b0;
        end
    end

    // Read mux, unimplemented bits and addresses return zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_ENABLE: bus_rdata = {en_q, 4'b0000};
            ADR_FLAG:   bus_rdata = {fl_e1, fl_e0, fl_pc, 5'b00000};
            ADR_SENSE:  bus_rdata = {6'b000000, sense_q};
            ADR_MSK_LO: bus_rdata = mask_q[MSK_W-1:0];
            ADR_MSK_HI: bus_rdata = mask_q[PC_N-1:MSK_W];
            default:    bus_rdata = '0;
        endcase
    end

    // Form the requests: level mode follows the pin, edge modes the flag
    always_comb begin
        if (sense_q == SNS_LOW) begin
            irq_ext0 = gie && en_q[2] && ext_low[0];
            irq_ext1 = gie && en_q[3] && ext_low[1];
        end else begin
            irq_ext0 = gie && en_q[2] && fl_e0;
            irq_ext1 = gie && en_q[3] && fl_e1;
        end
        irq_pc = gie && (en_q[1] || en_q[0]) && fl_pc;
    end

    // Requests never assert while the global enable is low
    assert_gie_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ext0 || irq_ext1 || irq_pc) |-> gie);

    // No external-0 flag appears while in low-level mode
    assert_level_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_q == SNS_LOW && !fl_e0 && !bus_wr) |=> !fl_e0);

    // With both groups disabled the pin-change flag cannot rise
    assert_group_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[1:0] == 2'b00 && !fl_pc && !bus_wr) |=> !fl_pc);

    // With every mask bit clear the pin-change flag cannot rise
    assert_mask_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && !fl_pc && !bus_wr) |=> !fl_pc);

    // Writing zero to a set flag bit leaves it set
    assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[BIT_EXT1] && !ack_ext1 && fl_e1) |=> fl_e1);

    // Acknowledge without a coincident event clears the pin-change flag
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pc && !pc_hit) |=> !fl_pc);

    // An event coinciding with an acknowledge still leaves the flag set
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hit[0] && ack_ext0) |=> fl_e0);
endmodule

// File: tb/tb_irq_front_end.sv
module tb_irq_front_end;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        gie = 1'b0;
    logic [1:0]  ext_pin = '0;
    logic [15:0] pc_pin = '0;
    logic        ack_ext0 = 1'b0, ack_ext1 = 1'b0, ack_pc = 1'b0;
    logic        irq_ext0, irq_ext1, irq_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_front_end dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
        .ext_pin(ext_pin), .pc_pin(pc_pin), .ack_ext0(ack_ext0),
        .ack_ext1(ack_ext1), .ack_pc(ack_pc), .irq_ext0(irq_ext0),
        .irq_ext1(irq_ext1), .irq_pc(irq_pc)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Wait for the three edges a pad change needs to reach a flag
    task automatic settle3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R4: reset state and reserved bits
        rd(6'h3B, v); chk("R1 reset", v, 8'h00);
        rd(6'h3A, v); chk("R2 reset", v, 8'h00);
        wr(6'h3B, 8'hFF); rd(6'h3B, v); chk("R1 reserved", v, 8'hF0);
        wr(6'h35, 8'hFF); rd(6'h35, v); chk("R4 reserved", v, 8'h03);
        wr(6'h3B, 8'h00);

        // R4: sweep edge modes x pin x direction
        for (int m = 1; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [7:0] exp;
                    logic hit;
                    wr(6'h35, 8'(m));
                    ext_pin[p] = (dir == 0) ? 1'b0 : 1'b1; // start level
                    idle(5);
                    wr(6'h3A, 8'hE0);
                    ext_pin[p] = ~ext_pin[p];
                    settle3();
                    // dir 0 is a rising transition, dir 1 a falling one
                    hit = (m == 1) || (m == 2 && dir == 1) || (m == 3 && dir == 0);
                    exp = hit ? ((p == 0) ? 8'h40 : 8'h80) : 8'h00;
                    rd(6'h3A, v); chk("R4 edge mode", v, exp);
                end
            end
        end
        ext_pin = 2'b00;
        idle(5);

        // R2 R3: request gating over enable x gie with both ext flags set
        wr(6'h35, 8'h01);
        ext_pin = 2'b11; settle3();
        rd(6'h3A, v); chk("R2 both ext flags", v, 8'hC0);
        for (int e = 0; e < 4; e++) begin
            for (int g = 0; g < 2; g++) begin
                wr(6'h3B, 8'(e << 6));
                gie = g[0];
                #1;
                chk("R3 irq_ext0", {7'b0, irq_ext0}, {7'b0, e[0] & g[0]});
                chk("R3 irq_ext1", {7'b0, irq_ext1}, {7'b0, e[1] & g[0]});
            end
        end

        // R8: write-zero keeps, write-one clears
        wr(6'h3A, 8'h00); rd(6'h3A, v); chk("R8 write zero", v, 8'hC0);
        wr(6'h3A, 8'h40); rd(6'h3A, v); chk("R8 write one", v, 8'h80);

        // R9: acknowledge clears ext1
        @(negedge clk); ack_ext1 = 1'b1; @(negedge clk); ack_ext1 = 1'b0;
        rd(6'h3A, v); chk("R9 ack ext1", v, 8'h00);

        // R10: acknowledge in the cycle the event sets the flag
        ext_pin[0] = 1'b0;           // falling change in any-change mode
        @(posedge clk); @(posedge clk); @(negedge clk);
        ack_ext0 = 1'b1;             // held across the setting edge
        @(negedge clk); ack_ext0 = 1'b0;
        rd(6'h3A, v); chk("R10 set wins", v & 8'h40, 8'h40);
        @(negedge clk); ack_ext0 = 1'b1; @(negedge clk); ack_ext0 = 1'b0;
        rd(6'h3A, v); chk("R9 ack ext0", v & 8'h40, 8'h00);
        ext_pin = 2'b00; idle(5); wr(6'h3A, 8'hE0);

        // R5: low-level mode on ext0
        wr(6'h35, 8'h00);
        ext_pin = 2'b11; idle(5);
        wr(6'h3A, 8'hE0);
        wr(6'h3B, 8'h40); gie = 1'b1;
        #1 chk("R5 high pin no request", {7'b0, irq_ext0}, 8'h00);
        ext_pin[0] = 1'b0;
        @(posedge clk); #1 chk("R5 one edge", {7'b0, irq_ext0}, 8'h00);
        @(posedge clk); #1 chk("R5 asserted", {7'b0, irq_ext0}, 8'h01);
        rd(6'h3A, v); chk("R5 no flag", v, 8'h00);
        ext_pin[0] = 1'b1;
        @(posedge clk); @(posedge clk); #1 chk("R5 released", {7'b0, irq_ext0}, 8'h00);
        ext_pin = 2'b00; idle(4);
        wr(6'h3B, 8'h00);

        // R6 R7: sweep every pin-change input x mask x group enables
        for (int i = 0; i < 16; i++) begin
            for (int mk = 0; mk < 2; mk++) begin
                for (int gc = 0; gc < 4; gc++) begin
                    logic [15:0] msk;
                    logic grp, fexp;
                    msk = (mk != 0) ? (16'h1 << i) : 16'h0000;
                    wr(6'h23, msk[7:0]);
                    wr(6'h22, msk[15:8]);
                    wr(6'h3B, 8'(gc << 4));
                    wr(6'h3A, 8'hE0);
                    pc_pin[i] = ~pc_pin[i];
                    settle3();
                    grp = (i >= 8 && i <= 11) ? gc[0] : gc[1];
                    fexp = (mk != 0) && grp;
                    rd(6'h3A, v);
                    if (mk == 0) chk("R7 masked pin", v, 8'h00);
                    else chk("R6 group coverage", v, fexp ? 8'h20 : 8'h00);
                    chk("R6 irq_pc", {7'b0, irq_pc}, {7'b0, fexp & (gc != 0)});
                end
            end
        end

        // R7: mask readback and R9 pin-change acknowledge
        wr(6'h23, 8'hA5); wr(6'h22, 8'h3C);
        rd(6'h23, v); chk("R7 mask lo", v, 8'hA5);
        rd(6'h22, v); chk("R7 mask hi", v, 8'h3C);
        wr(6'h3B, 8'h30);
        pc_pin[0] = ~pc_pin[0]; settle3();
        rd(6'h3A, v); chk("R6 flag before ack", v, 8'h20);
        @(negedge clk); ack_pc = 1'b1; @(negedge clk); ack_pc = 1'b0;
        rd(6'h3A, v); chk("R9 ack pc", v, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule